// File: doc/BRIEF.md
# Strap Pin Address and Pullup Decoder

This block derives a 7-bit I2C slave address and two input-pullup enables from two strap pins. Each strap can be tied to ground, to supply, to the SCL line or to the SDA line, so one strap carries one of four values. The block synchronizes both straps together with SCL and SDA. While the bus is active it compares each strap against the two bus lines to learn whether the strap follows one of them. The slave protocol engine sends a one-cycle strobe when a full START-to-STOP transfer has ended. On the first such strobe the block fixes the strap decode, and it holds that decode until reset.

Until that first strobe, each strap is treated as a static level. A strap that reads high decodes as supply and a strap that reads low decodes as ground. Straps wired to ground or supply therefore give the correct address from reset, whatever the bus is doing. Straps wired to an idle-high bus line show up as supply until the first transfer shows what they really follow. The upper strap controls the pullups of input ports 7..4 and the lower strap controls those of ports 3..0.

Top module: `strap_addr_decoder`

## Requirements
- R1: The address is {3'b110, F_hi, F_lo}. The upper strap field F_hi (bits 3:2) is SCL=00, SDA=01, GND=10, VCC=11. The lower strap field F_lo (bits 1:0) is GND=00, VCC=01, SCL=10, SDA=11. For example, both straps on ground give 1101000 and upper on SCL with lower on ground gives 1100000.
- R2: Before the first transfer strobe, each strap decodes as VCC if its synchronized pin is high and as GND if it is low. This holds regardless of SCL and SDA activity, so ground and supply combinations decode correctly from reset.
- R3: pullup_lo_en follows the lower strap and pullup_hi_en follows the upper strap. Each enable is 1 unless its strap decodes as GND.
- R4: On the first transfer strobe, a strap is classified as SCL if it matched SCL at both SCL levels at moments when SDA differed from it. Otherwise it is classified as SDA if the same holds with the roles of SCL and SDA swapped. Otherwise it takes the static level of its pin.
- R5: After the first strobe, the address and pullup enables hold until reset. Later strobes and changes on the straps, SCL or SDA have no effect.
- R6: While reset is applied, both straps decode as GND, the address is 1101000 and both pullup enables are 0.
- R7: Before the lock, a change on a strap pin reaches the outputs on the third rising clock edge after it is applied (two synchronizer stages and one output register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_hi | input | 1 | Upper strap pin (asynchronous) |
| strap_lo | input | 1 | Lower strap pin (asynchronous) |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| xfer_done | input | 1 | One-cycle strobe at the end of a complete bus transfer |
| slave_addr | output | 7 | Decoded slave address |
| pullup_lo_en | output | 1 | Pullup enable for input ports 3..0 |
| pullup_hi_en | output | 1 | Pullup enable for input ports 7..4 |

## Verification
The hardest case to reach is a strap that follows SDA or SCL. Its classification depends on the bus showing SCL low while SDA is high, and also SCL high while SDA is low, before the strobe arrives. The stimulus drives real START, data, acknowledge and STOP waveforms with data bytes that contain both ones and zeros, for all sixteen strap wirings. After the lock it rewires the straps and sends a second transfer and strobe to show that the decode holds. Extra cases hold the bus low through reset to show that static straps decode correctly, and one case times a strap edge to the exact cycle.

// File: rtl/strap_pkg.sv
package strap_pkg;
  // Connection kinds; this encoding equals the upper strap's address field.
  typedef enum logic [1:0] {
    CONN_SCL = 2'b00,
    CONN_SDA = 2'b01,
    CONN_GND = 2'b10,
    CONN_VCC = 2'b11
  } conn_e;

  // Evidence bit positions gathered per strap.
  localparam int EV_SCL_LO = 0;
  localparam int EV_SCL_HI = 1;
  localparam int EV_SDA_LO = 2;
  localparam int EV_SDA_HI = 3;
  localparam int EV_W      = 4;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/strap_classifier.sv
module strap_classifier
  import strap_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_s,
  input  logic  scl_s,
  input  logic  sda_s,
  input  logic  locked,
  input  logic  lock_now,
  output conn_e code_q,
  output logic  pu_q
);
  logic [EV_W-1:0] ev_q, ev_nxt;
  logic            is_scl, is_sda;
  conn_e           live, dec;

  // Collect evidence that the pin follows one bus line while the other differs.
  always_comb begin
    ev_nxt = ev_q;
    if (pin_s == scl_s && pin_s != sda_s) begin
      if (scl_s) ev_nxt[EV_SCL_HI] = 1'b1;
      else       ev_nxt[EV_SCL_LO] = 1'b1;
    end
    if (pin_s == sda_s && pin_s != scl_s) begin
      if (sda_s) ev_nxt[EV_SDA_HI] = 1'b1;
      else       ev_nxt[EV_SDA_LO] = 1'b1;
    end
  end

  assign is_scl = ev_nxt[EV_SCL_LO] & ev_nxt[EV_SCL_HI];
  assign is_sda = ev_nxt[EV_SDA_LO] & ev_nxt[EV_SDA_HI];
  assign live   = pin_s ? CONN_VCC : CONN_GND;

  always_comb begin
    if (is_scl)      dec = CONN_SCL;
    else if (is_sda) dec = CONN_SDA;
    else             dec = live;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= '0;
      code_q <= CONN_GND;
      pu_q   <= 1'b0;
    end else if (!locked) begin
      ev_q <= ev_nxt;
      if (lock_now) begin
        code_q <= dec;
        pu_q   <= is_scl | is_sda | pin_s;
      end else begin
        code_q <= live;
        pu_q   <= pin_s;
      end
    end
  end
endmodule

// File: rtl/strap_addr_decoder.sv
module strap_addr_decoder
  import strap_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-5:0] ADDR_PREFIX = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_hi,
  input  logic              strap_lo,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] slave_addr,
  output logic              pullup_lo_en,
  output logic              pullup_hi_en
);
  localparam int NSTRAP = 2;
  localparam int SYNC_W = NSTRAP + 2;
  localparam logic [1:0] LO_FIELD_XOR = 2'b10;

  logic [SYNC_W-1:0] raw_v, sync_v;
  logic              locked_q, lock_now;
  conn_e             code_w [NSTRAP];
  logic [NSTRAP-1:0] pu_w;

  assign raw_v = {strap_hi, strap_lo, scl_in, sda_in};

  strap_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_v),
    .q   (sync_v)
  );

  assign lock_now = xfer_done & ~locked_q;

  always_ff @(posedge clk) begin
    if (rst)           locked_q <= 1'b0;
    else if (lock_now) locked_q <= 1'b1;
  end

  // Index 0 is the lower strap, index 1 the upper strap.
  for (genvar g = 0; g < NSTRAP; g++) begin : g_strap
    strap_classifier u_cls (
      .clk      (clk),
      .rst      (rst),
      .pin_s    (sync_v[2+g]),
      .scl_s    (sync_v[1]),
      .sda_s    (sync_v[0]),
      .locked   (locked_q),
      .lock_now (lock_now),
      .code_q   (code_w[g]),
      .pu_q     (pu_w[g])
    );
  end

  assign slave_addr   = {ADDR_PREFIX, code_w[1], code_w[0] ^ LO_FIELD_XOR};
  assign pullup_lo_en = pu_w[0];
  assign pullup_hi_en = pu_w[1];
endmodule

// File: rtl/strap_addr_checker.sv
module strap_addr_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_done,
  input logic              locked,
  input logic [ADDR_W-1:0] addr,
  input logic              pu_lo,
  input logic              pu_hi
);
  // R2: before the lock, both straps decode as GND or VCC only
  a_r2_prelock_static: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (addr[3] == 1'b1 && addr[1] == 1'b0));

  // R3: each pullup enable agrees with its strap field
  a_r3_pu_lo_field: assert property (@(posedge clk) disable iff (rst)
    pu_lo == (addr[1:0] != 2'b00));
  a_r3_pu_hi_field: assert property (@(posedge clk) disable iff (rst)
    pu_hi == (addr[3:2] != 2'b10));

  // R5: a strobe locks the decode, and a locked decode holds
  a_r5_strobe_locks: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> locked);
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
  a_r5_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(addr) && $stable(pu_lo) && $stable(pu_hi)));

  // R6: reset values
  a_r6_reset_state: assert property (@(posedge clk)
    rst |=> (addr[3:0] == 4'b1000 && !pu_lo && !pu_hi && !locked));
endmodule

bind strap_addr_decoder strap_addr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .xfer_done (xfer_done),
  .locked    (locked_q),
  .addr      (slave_addr),
  .pu_lo     (pullup_lo_en),
  .pu_hi     (pullup_hi_en)
);

// File: tb/sim_strap_addr_decoder.sv
module sim_strap_addr_decoder;
  localparam int SYNC = 2;
  localparam int WATCHDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, xfer = 1'b0;
  int   mhi = 2, mlo = 2;   // wiring: 0 SCL, 1 SDA, 2 GND, 3 VCC
  logic s_hi, s_lo;
  logic [6:0] addr;
  logic pul, puh;
  int   checks = 0, failures = 0;
  bit   done = 1'b0;

  function automatic logic pin_of(int m, logic c, logic d);
    case (m)
      0: return c;
      1: return d;
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  always_comb s_hi = pin_of(mhi, scl, sda);
  always_comb s_lo = pin_of(mlo, scl, sda);

  strap_addr_decoder u0 (
    .clk (clk), .rst (rst), .strap_hi (s_hi), .strap_lo (s_lo),
    .scl_in (scl), .sda_in (sda), .xfer_done (xfer),
    .slave_addr (addr), .pullup_lo_en (pul), .pullup_hi_en (puh)
  );

  always #2 clk = ~clk;

  // Behavioural reference: a delay queue plus per-strap evidence flags
  logic [3:0] hq [$];
  int  mc [2];
  bit  mpu [2];
  bit  ev [2][4];
  bit  mlock;

  function automatic logic [6:0] exp_addr(int hi, int lo);
    logic [1:0] fh, fl;
    fh = 2'(hi);
    fl = 2'(lo) ^ 2'b10;
    return {3'b110, fh, fl};
  endfunction

  always @(posedge clk) begin
    logic [3:0] d;
    logic p, c, a;
    if (rst) begin
      hq = {};
      repeat (SYNC) hq.push_back(4'b0);
      for (int g = 0; g < 2; g++) begin
        mc[g] = 2; mpu[g] = 1'b0;
        for (int k = 0; k < 4; k++) ev[g][k] = 1'b0;
      end
      mlock = 1'b0;
    end else begin
      hq.push_back({s_hi, s_lo, scl, sda});
      d = hq.pop_front();
      c = d[1];
      a = d[0];
      if (!mlock) begin
        for (int g = 0; g < 2; g++) begin
          p = (g == 1) ? d[3] : d[2];
          if (p == c && p != a) ev[g][c ? 1 : 0] = 1'b1;
          if (p == a && p != c) ev[g][a ? 3 : 2] = 1'b1;
          if (xfer) begin
            if (ev[g][0] && ev[g][1])      mc[g] = 0;
            else if (ev[g][2] && ev[g][3]) mc[g] = 1;
            else                           mc[g] = p ? 3 : 2;
            mpu[g] = (mc[g] != 2);
          end else begin
            mc[g]  = p ? 3 : 2;
            mpu[g] = p;
          end
        end
        if (xfer) mlock = 1'b1;
      end
    end
  end

  // Cycle-by-cycle comparison against the reference (R1, R3 via model)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (addr !== exp_addr(mc[1], mc[0]) || pul !== mpu[0] || puh !== mpu[1]) begin
        failures++;
        $display("FAIL R1/R3 model t=%0t addr=%b pl=%b ph=%b exp addr=%b pl=%b ph=%b",
                 $time, addr, pul, puh, exp_addr(mc[1], mc[0]), mpu[0], mpu[1]);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [6:0] ea, logic epl, logic eph);
    checks++;
    if (addr !== ea || pul !== epl || puh !== eph) begin
      failures++;
      $display("FAIL %s addr=%b pl=%b ph=%b exp addr=%b pl=%b ph=%b",
               tag, addr, pul, puh, ea, epl, eph);
    end
  endtask

  task automatic bus_xfer(logic [7:0] b);
    sda = 1'b0; cyc(3);                       // START
    for (int i = 8; i >= 0; i--) begin        // 8 data bits, then ack low
      scl = 1'b0; cyc(2);
      sda = (i > 0) ? b[i-1] : 1'b0; cyc(2);
      scl = 1'b1; cyc(3);
    end
    scl = 1'b0; cyc(2);
    sda = 1'b0; cyc(2);
    scl = 1'b1; cyc(3);
    sda = 1'b1; cyc(3);                       // STOP
    xfer = 1'b1; cyc(1);
    xfer = 1'b0;
  endtask

  task automatic run_case(int hi, int lo, bit bus_low);
    int ph, pl;
    mhi = hi; mlo = lo;
    scl = !bus_low; sda = !bus_low;
    rst = 1'b1; cyc(3);
    chk("R6 reset state", 7'b1101000, 1'b0, 1'b0);
    rst = 1'b0; cyc(5);
    ph = pin_of(hi, scl, sda) ? 3 : 2;
    pl = pin_of(lo, scl, sda) ? 3 : 2;
    // R2: static decode before any transfer
    chk("R2 prelock decode", exp_addr(ph, pl), pl != 2, ph != 2);
    scl = 1'b1; sda = 1'b1; cyc(4);
    bus_xfer(8'hA5); cyc(4);
    // R4 and R1: classified wiring
    chk("R4 classified", exp_addr(hi, lo), lo != 2, hi != 2);
    mhi = 2; mlo = 3; cyc(4);
    bus_xfer(8'h3C); cyc(4);
    // R5: rewiring and a second strobe are ignored
    chk("R5 locked hold", exp_addr(hi, lo), lo != 2, hi != 2);
  endtask

  initial begin
    // Directed address examples (R1)
    run_case(2, 2, 1'b0);
    chk("R1 gnd/gnd 1101000", 7'b1101000, 1'b0, 1'b0);
    run_case(3, 3, 1'b0);
    chk("R1 vcc/vcc 1101101", 7'b1101101, 1'b1, 1'b1);
    run_case(0, 2, 1'b0);
    chk("R1 scl/gnd 1100000", 7'b1100000, 1'b0, 1'b1);
    run_case(3, 2, 1'b0);
    chk("R3 hi only pullup", 7'b1101100, 1'b0, 1'b1);
    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 4; l++)
        run_case(h, l, 1'b0);
    // R2: bus held low through reset, static straps still decode
    run_case(3, 2, 1'b1);
    run_case(2, 3, 1'b1);
    run_case(0, 1, 1'b1);
    // R7: latency of a strap edge before the lock
    mhi = 2; mlo = 2; scl = 1'b1; sda = 1'b1;
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(5);
    mlo = 3; cyc(2);
    chk("R7 before third edge", 7'b1101000, 1'b0, 1'b0);
    cyc(1);
    chk("R7 at third edge", 7'b1101001, 1'b1, 1'b0);
    cyc(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule